// File: doc/BRIEF.md
# UART Xon/Xoff Software Flow Controller

This block sits between a UART receive shifter and its receive FIFO and carries out in-band software flow control. Every received byte is compared against four programmable control characters: two resume characters and two suspend characters. In single-character mode one byte is enough for a match. In two-character mode the first and then the second character of a pair must arrive back to back. A matched control character never reaches the FIFO. All other bytes are passed on through a registered store strobe.

A suspend match raises a transmitter halt. The halt takes effect only once the transmitter reports that no character is in progress. It also sets an interrupt status flag when that interrupt is enabled. A later resume match clears both. Separately, the block watches the receive FIFO fill level. It pulses a request to send a suspend character when the level climbs to the threshold tied to the selected trigger level, and it pulses a request to send a resume character when the level drains back to the matching low mark.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset all four control characters hold 0x00, and storeEn, txHalt, xoffFlag, sendXon and sendXoff are all 0.
- R2: A write with regWrEn high loads regWrData into the character chosen by regWrSel: 0 resume-first, 1 resume-second, 2 suspend-first, 3 suspend-second.
- R3: With fcMode 0 (off), every received byte is presented on storeEn/storeData one cycle after its rxValid, in arrival order, and no byte changes txHalt.
- R4: With fcMode 1 (single), a byte equal to suspend-first is a suspend match, and this comparison wins when both characters are equal. Otherwise a byte equal to resume-first is a resume match. A matched byte is not stored; any other byte is stored.
- R5: With fcMode 2 or 3 (double), suspend-first followed directly by suspend-second is a suspend match, and resume-first followed directly by resume-second is a resume match; neither byte of a matched pair is stored.
- R6: In double mode, a held first-character byte followed by a byte that does not complete its pair causes both bytes to be stored in arrival order: the held byte one cycle after the second byte's rxValid, and the second byte one cycle after that. Received bytes are at least two cycles apart.
- R7: After a suspend match, txHalt rises at the first clock edge where txBusy is low, which may be the edge of the match itself. It stays high until a resume match clears it at that match's edge.
- R8: A suspend match sets xoffFlag only when irqEn is high; a resume match clears xoffFlag.
- R9: With flow control on, a one-cycle sendXoff pulse is issued when fifoCount first reaches the high mark, and no further pulse follows while the fill level stays at or above it. The high mark is 16, 24, 28 or 28 for trigSel 0, 1, 2 or 3.
- R10: After a sendXoff, a one-cycle sendXon pulse is issued once when fifoCount drops to the low mark. The low mark is 0, 7, 15 or 23 for trigSel 0, 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Control character write strobe |
| regWrSel | input | 2 | Character select for the write |
| regWrData | input | DATA_W | Character value to write |
| fcMode | input | 2 | 0 off, 1 single, 2 or 3 double |
| rxValid | input | 1 | Received byte strobe |
| rxData | input | DATA_W | Received byte |
| txBusy | input | 1 | Transmitter has a character in progress |
| irqEn | input | 1 | Enables setting of the suspend status flag |
| trigSel | input | 2 | Receive trigger level select (8/16/24/28) |
| fifoCount | input | CNT_W | Receive FIFO fill level |
| storeEn | output | 1 | Write strobe to the receive FIFO |
| storeData | output | DATA_W | Byte to write into the receive FIFO |
| txHalt | output | 1 | Transmitter must not start a new character |
| xoffFlag | output | 1 | Suspend-received interrupt status |
| sendXon | output | 1 | One-cycle request to transmit a resume character |
| sendXoff | output | 1 | One-cycle request to transmit a suspend character |

## Verification
The bench builds the block with its defaults, DATA_W of 8 and CNT_W of 6. The 6-bit count reaches a full FIFO of 32, so every high and low mark for all four trigger selections can be driven, including the shared mark of 28 and fill levels above it. The 8-bit characters let the bench cover reset-equal characters, where the suspend comparison wins, and byte streams that mix each control character with ordinary data in every mode.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    HOLD_NONE = 2'd0,
    HOLD_XON  = 2'd1,
    HOLD_XOFF = 2'd2
  } holdKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic storeRx;     // pass current byte to the FIFO
    logic storeHeld;   // pass held first byte to the FIFO
    logic captureHeld; // remember current byte as a pending first byte
    logic spillRx;     // keep current byte for the following cycle
  } dpStrobe_t;

  // comparator results, bit i = match against character i
  typedef struct packed {
    logic eqXoff2;
    logic eqXoff1;
    logic eqXon2;
    logic eqXon1;
  } cmpFlag_t;

  localparam int NUM_CHARS = 4;

  function automatic int unsigned highMark(input logic [1:0] trig);
    int unsigned base;
    base = (int'(trig) + 1) * 8;
    return (base + 8 > 28) ? 28 : base + 8;
  endfunction

  function automatic int unsigned lowMark(input logic [1:0] trig);
    return (trig == 2'd0) ? 0 : int'(trig) * 8 - 1;
  endfunction

endpackage

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] rxData,
  input  dpStrobe_t         strobe,
  output cmpFlag_t          cmp,
  output logic              storeEn,
  output logic [DATA_W-1:0] storeData
);

  logic [NUM_CHARS-1:0][DATA_W-1:0] ctrlChar;
  logic [NUM_CHARS-1:0]             eqVec;
  logic [DATA_W-1:0]                heldByte;
  logic [DATA_W-1:0]                spillByte;
  logic                             spillValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlChar <= '0;
    end else if (regWrEn) begin
      ctrlChar[regWrSel] <= regWrData;
    end
  end

  for (genvar i = 0; i < NUM_CHARS; i++) begin : g_cmp
    assign eqVec[i] = (rxData == ctrlChar[i]);
  end

  assign cmp = cmpFlag_t'(eqVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldByte <= '0;
    end else if (strobe.captureHeld) begin
      heldByte <= rxData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeEn    <= 1'b0;
      storeData  <= '0;
      spillByte  <= '0;
      spillValid <= 1'b0;
    end else begin
      storeEn <= 1'b0;
      if (strobe.storeHeld) begin
        storeEn   <= 1'b1;
        storeData <= heldByte;
      end else if (spillValid) begin
        storeEn    <= 1'b1;
        storeData  <= spillByte;
        spillValid <= 1'b0;
      end else if (strobe.storeRx) begin
        storeEn   <= 1'b1;
        storeData <= rxData;
      end
      if (strobe.spillRx) begin
        spillByte  <= rxData;
        spillValid <= 1'b1;
      end
    end
  end

  // R6
  rx_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    spillValid |-> !(strobe.storeRx || strobe.storeHeld));

endmodule

// File: rtl/sfc_control.sv
module sfc_control
  import sfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] fcMode,
  input  logic       rxValid,
  input  cmpFlag_t   cmp,
  input  logic       txBusy,
  input  logic       irqEn,
  output dpStrobe_t  strobe,
  output logic       txHalt,
  output logic       xoffFlag
);

  holdKind_t holdKind, holdNext;
  logic      matchXon, matchXoff;
  logic      haltPend;

  always_comb begin
    strobe    = '0;
    holdNext  = holdKind;
    matchXon  = 1'b0;
    matchXoff = 1'b0;
    if (rxValid) begin
      if (fcMode == 2'd0) begin
        strobe.storeRx = 1'b1;
        holdNext       = HOLD_NONE;
      end else if (fcMode == 2'd1) begin
        holdNext = HOLD_NONE;
        if (cmp.eqXoff1)     matchXoff      = 1'b1;
        else if (cmp.eqXon1) matchXon       = 1'b1;
        else                 strobe.storeRx = 1'b1;
      end else begin
        case (holdKind)
          HOLD_XOFF: begin
            holdNext = HOLD_NONE;
            if (cmp.eqXoff2) matchXoff = 1'b1;
            else begin
              strobe.storeHeld = 1'b1;
              strobe.spillRx   = 1'b1;
            end
          end
          HOLD_XON: begin
            holdNext = HOLD_NONE;
            if (cmp.eqXon2) matchXon = 1'b1;
            else begin
              strobe.storeHeld = 1'b1;
              strobe.spillRx   = 1'b1;
            end
          end
          default: begin
            if (cmp.eqXoff1) begin
              strobe.captureHeld = 1'b1;
              holdNext           = HOLD_XOFF;
            end else if (cmp.eqXon1) begin
              strobe.captureHeld = 1'b1;
              holdNext           = HOLD_XON;
            end else begin
              strobe.storeRx = 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdKind <= HOLD_NONE;
      haltPend <= 1'b0;
      txHalt   <= 1'b0;
      xoffFlag <= 1'b0;
    end else begin
      holdKind <= holdNext;
      if (matchXon) begin
        haltPend <= 1'b0;
        txHalt   <= 1'b0;
        xoffFlag <= 1'b0;
      end else begin
        if ((matchXoff || haltPend) && !txBusy) begin
          txHalt   <= 1'b1;
          haltPend <= 1'b0;
        end else if (matchXoff) begin
          haltPend <= 1'b1;
        end
        if (matchXoff && irqEn) xoffFlag <= 1'b1;
      end
    end
  end

  // R7
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txHalt) |-> $past(!txBusy));

  // R7
  halt_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txHalt) |-> $past(rxValid && fcMode != 2'd0));

  // R8
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xoffFlag) |-> $past(irqEn && rxValid));

endmodule

// File: rtl/sfc_level_watch.sv
module sfc_level_watch
  import sfc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       trigSel,
  input  logic [CNT_W-1:0] fifoCount,
  output logic             sendXon,
  output logic             sendXoff
);

  logic [CNT_W-1:0] hiMark, loMark;
  logic             throttled;

  assign hiMark = CNT_W'(highMark(trigSel));
  assign loMark = CNT_W'(lowMark(trigSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      throttled <= 1'b0;
      sendXon   <= 1'b0;
      sendXoff  <= 1'b0;
    end else begin
      sendXon  <= 1'b0;
      sendXoff <= 1'b0;
      if (!enable) begin
        throttled <= 1'b0;
      end else if (!throttled && fifoCount >= hiMark) begin
        throttled <= 1'b1;
        sendXoff  <= 1'b1;
      end else if (throttled && fifoCount <= loMark) begin
        throttled <= 1'b0;
        sendXon   <= 1'b1;
      end
    end
  end

  // R9
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sendXon && sendXoff));

  // R9
  xoff_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendXoff |=> !sendXoff);

  // R10
  xon_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendXon |=> !sendXon);

endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl
  import sfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [1:0]        fcMode,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              txBusy,
  input  logic              irqEn,
  input  logic [1:0]        trigSel,
  input  logic [CNT_W-1:0]  fifoCount,
  output logic              storeEn,
  output logic [DATA_W-1:0] storeData,
  output logic              txHalt,
  output logic              xoffFlag,
  output logic              sendXon,
  output logic              sendXoff
);

  dpStrobe_t strobe;
  cmpFlag_t  cmp;

  sfc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .rxData(rxData), .strobe(strobe), .cmp(cmp),
    .storeEn(storeEn), .storeData(storeData)
  );

  sfc_control u_ctl (
    .clk(clk), .rstN(rstN), .fcMode(fcMode), .rxValid(rxValid),
    .cmp(cmp), .txBusy(txBusy), .irqEn(irqEn),
    .strobe(strobe), .txHalt(txHalt), .xoffFlag(xoffFlag)
  );

  sfc_level_watch #(.CNT_W(CNT_W)) u_lvl (
    .clk(clk), .rstN(rstN), .enable(fcMode != 2'd0),
    .trigSel(trigSel), .fifoCount(fifoCount),
    .sendXon(sendXon), .sendXoff(sendXoff)
  );

endmodule

// File: tb/xonxoff_flow_ctrl_bench.sv
module xonxoff_flow_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0, rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regWrSel = '0;
  logic [7:0] regWrData = '0;
  logic [1:0] fcMode = '0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       txBusy = 1'b0, irqEn = 1'b0;
  logic [1:0] trigSel = '0;
  logic [5:0] fifoCount = '0;
  logic       storeEn, txHalt, xoffFlag, sendXon, sendXoff;
  logic [7:0] storeData;

  int testsRun = 0, testsFailed = 0;
  int xonPulses = 0, xoffPulses = 0;
  logic [7:0] expQ[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xonxoff_flow_ctrl u_xonxoff_flow_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .fcMode(fcMode), .rxValid(rxValid), .rxData(rxData),
    .txBusy(txBusy), .irqEn(irqEn), .trigSel(trigSel), .fifoCount(fifoCount),
    .storeEn(storeEn), .storeData(storeData), .txHalt(txHalt),
    .xoffFlag(xoffFlag), .sendXon(sendXon), .sendXoff(sendXoff)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: scoreboard pops, pulse counters
  always @(negedge clk) begin
    if (rstN && storeEn) begin
      testsRun++;
      if (expQ.size() == 0) begin
        testsFailed++;
        $display("FAIL R3 unexpected store actual=%0h expected=none", storeData);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        if (storeData != e) begin
          testsFailed++;
          $display("FAIL R3 store data actual=%0h expected=%0h", storeData, e);
        end
      end
    end
    if (sendXon)  xonPulses++;
    if (sendXoff) xoffPulses++;
  end

  task automatic writeChar(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // drive one byte; stored bytes are pushed by caller expectation
  task automatic sendByte(input logic [7:0] b, input bit expectStore);
    if (expectStore) expQ.push_back(b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 storeEn", storeEn, 0);
    check("R1 txHalt", txHalt, 0);
    check("R1 xoffFlag", xoffFlag, 0);
    check("R1 pulses", sendXon + sendXoff, 0);

    // R1/R4: all characters zero, suspend wins
    fcMode = 2'd1;
    sendByte(8'h00, 0);
    check("R1 zero char halts", txHalt, 1);
    check("R4 suspend priority flag off", xoffFlag, 0);
    writeChar(2'd0, 8'h11);
    sendByte(8'h11, 0);
    check("R4 resume match", txHalt, 0);

    // R2 program remaining characters
    writeChar(2'd1, 8'h12);
    writeChar(2'd2, 8'h13);
    writeChar(2'd3, 8'h14);

    // R3 mode off: everything stored
    fcMode = 2'd0;
    sendByte(8'h13, 1);
    sendByte(8'h41, 1);
    sendByte(8'h11, 1);
    check("R3 no halt in off mode", txHalt, 0);
    check("R3 queue drained", expQ.size(), 0);

    // R4/R7/R8 single mode
    fcMode = 2'd1; irqEn = 1'b1;
    sendByte(8'h41, 1);
    sendByte(8'h13, 0);
    check("R7 halt on suspend", txHalt, 1);
    check("R8 flag set", xoffFlag, 1);
    sendByte(8'h42, 1);
    sendByte(8'h11, 0);
    check("R7 halt cleared", txHalt, 0);
    check("R8 flag cleared", xoffFlag, 0);

    // R7 wait for transmitter idle
    @(negedge clk); txBusy = 1'b1;
    sendByte(8'h13, 0);
    idle(3);
    check("R7 halt waits for busy", txHalt, 0);
    txBusy = 1'b0;
    @(negedge clk);
    check("R7 halt after busy drops", txHalt, 1);
    sendByte(8'h11, 0);
    check("R7 resume", txHalt, 0);

    // R8 flag gated
    irqEn = 1'b0;
    sendByte(8'h13, 0);
    check("R8 flag gated off", xoffFlag, 0);
    check("R8 halt still set", txHalt, 1);
    sendByte(8'h11, 0);

    // R2 rewrite suspend-first
    writeChar(2'd2, 8'h20);
    sendByte(8'h13, 1);
    check("R2 old char no longer matches", txHalt, 0);
    sendByte(8'h20, 0);
    check("R2 new char matches", txHalt, 1);
    sendByte(8'h11, 0);
    writeChar(2'd2, 8'h13);

    // R5 double mode pairs
    fcMode = 2'd2;
    sendByte(8'h13, 0);
    sendByte(8'h14, 0);
    check("R5 pair suspend", txHalt, 1);
    sendByte(8'h11, 0);
    check("R5 first resume char alone keeps halt", txHalt, 1);
    sendByte(8'h12, 0);
    check("R5 pair resume", txHalt, 0);

    // R6 broken pairs released in order
    sendByte(8'h13, 1);
    expQ.push_back(8'h41);
    @(negedge clk); rxValid = 1'b1; rxData = 8'h41;
    @(negedge clk); rxValid = 1'b0;
    check("R6 held byte first", (storeEn && storeData == 8'h13) ? 1 : 0, 1);
    idle(3);
    sendByte(8'h11, 1);
    sendByte(8'h55, 1);
    sendByte(8'h14, 1);
    check("R6 no halt from broken pair", txHalt, 0);
    check("R6 queue drained", expQ.size(), 0);

    // R9/R10 level thresholds for each trigger select
    fcMode = 2'd1;
    for (int t = 0; t < 4; t++) begin
      int hi, lo;
      hi = (t == 0) ? 16 : (t == 1) ? 24 : 28;
      lo = (t == 0) ? 0 : (t == 1) ? 7 : (t == 2) ? 15 : 23;
      trigSel = 2'(t);
      fifoCount = 6'(hi - 1);
      idle(2);
      xonPulses = 0; xoffPulses = 0;
      idle(3);
      check($sformatf("R9 below mark t%0d", t), xoffPulses, 0);
      fifoCount = 6'(hi);
      idle(5);
      fifoCount = 6'd31;
      idle(3);
      check($sformatf("R9 one xoff t%0d", t), xoffPulses, 1);
      fifoCount = 6'(lo + 1);
      idle(3);
      check($sformatf("R10 above low mark t%0d", t), xonPulses, 0);
      fifoCount = 6'(lo);
      idle(5);
      check($sformatf("R10 one xon t%0d", t), xonPulses, 1);
      fifoCount = 6'd0;
      idle(2);
    end

    check("R3 final queue empty", expQ.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule